// File: doc/BRIEF.md
# Programmable Watchdog Timer with Ordered Two-Write Refresh

This block is a watchdog that asks for a system reset when software stops servicing it. It can be started in two ways. A strap input is sampled while the system reset is asserted. Software can also start it by writing a start bit. Once it is running, nothing but a system reset with the strap low returns it to idle.

The block has three states, with these transitions:
- `WG_IDLE` moves to `WG_COUNT` on a start write.
- `WG_COUNT` stays in `WG_COUNT` and reloads the counter on a valid refresh.
- `WG_COUNT` moves to `WG_FIRE` when the counter overflows.
- `WG_FIRE` moves back to `WG_COUNT`, with a reload, after the pulse length.

A separate handshake machine has two states, `SEQ_IDLE` and `SEQ_ARMED`. An arm-only write moves it to `SEQ_ARMED`. The next bus write moves it back to `SEQ_IDLE`, and that write is a refresh if it carries the start bit.

The timebase divides the clock by 12 and then by 2 or by 32. Each step of the timebase advances a 16-bit counter. The upper 7 bits of that counter are loaded from a reload value and the lower 9 bits are loaded with zero. On overflow the block raises a reset request for 24 cycles and sets a sticky status flag. It then reloads the counter and keeps counting. Bus address decoding is outside the block. The block sees only a write strobe and the two bit values being written.

Top module: `wdt_guard`

## Requirements
- R1: While `rst_ni` is low, `strap_i` is sampled. If it was high when reset ends, `running_o` is 1 and the first timeout comes after one full period. If it was low, `running_o` is 0 and no reset request is ever raised.
- R2: A change of `strap_i` after reset has ended does not start the watchdog.
- R3: When the watchdog is idle, a bus write with `wr_start_i`=1 starts it and loads the counter from `reload_i`.
- R4: A refresh happens only on a bus write with `wr_start_i`=1 whose previous bus write had `wr_arm_i`=1 and `wr_start_i`=0. Idle cycles between the two writes are allowed. Any other bus write cancels the pending arm. `arm_pending_o` shows the pending arm.
- R5: The timeout period is 12·P·(65536 − 512·`reload_i`) cycles, counted from the load edge. P is 2 when `presc_sel_i`=0 and 32 when `presc_sel_i`=1.
- R6: `wdt_rst_o` is high for exactly 24 cycles per timeout. After that the counter reloads and the next timeout follows one full period later. `running_o` stays 1 throughout.
- R7: A timeout sets `flag_o`. The flag survives the request pulse and clears on `flag_clr_i`.
- R8: Once the watchdog is running, no input can stop it except `rst_ni` low with `strap_i` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | System reset, active low, asynchronous |
| strap_i | input | 1 | Start strap, sampled during reset |
| bus_wr_i | input | 1 | One-cycle strobe marking any bus write |
| wr_arm_i | input | 1 | Arm bit value in this write |
| wr_start_i | input | 1 | Start/refresh bit value in this write |
| reload_i | input | 7 | Upper counter bits loaded on start, refresh or timeout |
| presc_sel_i | input | 1 | 0: divide tick by 2, 1: divide tick by 32 |
| flag_clr_i | input | 1 | Clears the timeout flag |
| wdt_rst_o | output | 1 | Reset request pulse |
| flag_o | output | 1 | Sticky timeout flag |
| running_o | output | 1 | Watchdog is running |
| arm_pending_o | output | 1 | First refresh write seen, second not yet |

## Verification
The refresh handshake is driven with a table of three-slot write patterns, each applied halfway through a known period:
- arm then start, which is accepted;
- start then arm, which is rejected;
- arm, an unrelated write, then start, which is rejected;
- arm, an idle cycle, then start, which is accepted;
- a lone start, which is rejected;
- a doubled arm then start, which is accepted.

Whether a timeout appears at the exact end of the original period tells a refresh apart from a non-refresh. Directed tests cover the strap levels at reset, strap toggling after reset, the exact period and pulse length, flag stickiness, a second reload value, and the slow prescaler.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;
    typedef enum logic [1:0] {
        WG_IDLE  = 2'd0,
        WG_COUNT = 2'd1,
        WG_FIRE  = 2'd2
    } wg_state_e;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_ARMED = 1'b1
    } seq_state_e;
endpackage

// File: rtl/wdt_guard_timebase.sv
module wdt_guard_timebase #(
    parameter int TICK_DIV = 12,
    parameter int PRE_FAST = 2,
    parameter int PRE_SLOW = 32
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic enable_i,
    input  logic slow_i,
    output logic step_o
);
    localparam int DIV_W = $clog2(TICK_DIV);
    localparam int PRE_W = $clog2(PRE_SLOW);
    localparam logic [DIV_W-1:0] DIV_LIM  = DIV_W'(TICK_DIV - 1);
    localparam logic [PRE_W-1:0] FAST_LIM = PRE_W'(PRE_FAST - 1);
    localparam logic [PRE_W-1:0] SLOW_LIM = PRE_W'(PRE_SLOW - 1);

    logic [DIV_W-1:0] div_q;
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] pre_lim;
    logic             tick;

    always_comb begin
        pre_lim = slow_i ? SLOW_LIM : FAST_LIM;
        tick    = enable_i && (div_q == DIV_LIM);
        step_o  = tick && (pre_q >= pre_lim);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            div_q <= '0;
            pre_q <= '0;
        end else if (clear_i) begin
            div_q <= '0;
            pre_q <= '0;
        end else if (enable_i) begin
            div_q <= tick ? '0 : div_q + 1'b1;
            if (tick) begin
                pre_q <= (pre_q >= pre_lim) ? '0 : pre_q + 1'b1;
            end
        end
    end

    assert_div_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        div_q <= DIV_LIM);
endmodule

// File: rtl/wdt_guard_handshake.sv
module wdt_guard_handshake
    import wdt_guard_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic wr_i,
    input  logic arm_i,
    input  logic start_i,
    output logic refresh_o,
    output logic pending_o
);
    seq_state_e seq_q, seq_d;

    always_comb begin
        seq_d = seq_q;
        if (wr_i) begin
            unique case (seq_q)
                SEQ_IDLE:  seq_d = (arm_i && !start_i) ? SEQ_ARMED : SEQ_IDLE;
                SEQ_ARMED: seq_d = (arm_i && !start_i) ? SEQ_ARMED : SEQ_IDLE;
                default:   seq_d = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) seq_q <= SEQ_IDLE;
        else         seq_q <= seq_d;
    end

    always_comb begin
        pending_o = (seq_q == SEQ_ARMED);
        refresh_o = pending_o && wr_i && start_i;
    end

    assert_refresh_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        refresh_o |=> !pending_o);
    assert_pending_from_arm_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pending_o) |-> $past(wr_i && arm_i));
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
    import wdt_guard_pkg::*;
#(
    parameter int TICK_DIV  = 12,
    parameter int PRE_FAST  = 2,
    parameter int PRE_SLOW  = 32,
    parameter int CNT_W     = 16,
    parameter int RELOAD_W  = 7,
    parameter int PULSE_LEN = 24
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                strap_i,
    input  logic                bus_wr_i,
    input  logic                wr_arm_i,
    input  logic                wr_start_i,
    input  logic [RELOAD_W-1:0] reload_i,
    input  logic                presc_sel_i,
    input  logic                flag_clr_i,
    output logic                wdt_rst_o,
    output logic                flag_o,
    output logic                running_o,
    output logic                arm_pending_o
);
    localparam int LOW_W = CNT_W - RELOAD_W;
    localparam int PC_W  = $clog2(PULSE_LEN);
    localparam logic [PC_W-1:0]  PC_LAST = PC_W'(PULSE_LEN - 1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    wg_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [PC_W-1:0]  pc_q;
    logic             flag_q;
    logic             refresh, start_req, step, load, fire_enter;

    wdt_guard_handshake u_handshake (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_i      (bus_wr_i),
        .arm_i     (wr_arm_i),
        .start_i   (wr_start_i),
        .refresh_o (refresh),
        .pending_o (arm_pending_o)
    );

    wdt_guard_timebase #(
        .TICK_DIV (TICK_DIV),
        .PRE_FAST (PRE_FAST),
        .PRE_SLOW (PRE_SLOW)
    ) u_timebase (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clear_i  (load),
        .enable_i (state_q == WG_COUNT),
        .slow_i   (presc_sel_i),
        .step_o   (step)
    );

    assign start_req = bus_wr_i && wr_start_i;

    always_comb begin
        state_d    = state_q;
        load       = 1'b0;
        fire_enter = 1'b0;
        unique case (state_q)
            WG_IDLE: begin
                if (start_req) begin
                    state_d = WG_COUNT;
                    load    = 1'b1;
                end
            end
            WG_COUNT: begin
                if (refresh) begin
                    load = 1'b1;
                end else if (step && cnt_q == CNT_MAX) begin
                    state_d    = WG_FIRE;
                    fire_enter = 1'b1;
                end
            end
            WG_FIRE: begin
                if (pc_q == PC_LAST) begin
                    state_d = WG_COUNT;
                    load    = 1'b1;
                end
            end
            default: state_d = WG_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= strap_i ? WG_COUNT : WG_IDLE;
        else         state_q <= state_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q  <= {reload_i, {LOW_W{1'b0}}};
            pc_q   <= '0;
            flag_q <= 1'b0;
        end else begin
            if (load)
                cnt_q <= {reload_i, {LOW_W{1'b0}}};
            else if (state_q == WG_COUNT && step)
                cnt_q <= cnt_q + 1'b1;
            pc_q <= (state_q == WG_FIRE) ? pc_q + 1'b1 : '0;
            if (fire_enter)      flag_q <= 1'b1;
            else if (flag_clr_i) flag_q <= 1'b0;
        end
    end

    always_comb begin
        wdt_rst_o = (state_q == WG_FIRE);
        running_o = (state_q != WG_IDLE);
        flag_o    = flag_q;
    end

    assert_no_stop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        running_o |=> running_o);
    assert_flag_on_fire_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(wdt_rst_o) |-> flag_o);
    assert_pulse_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wdt_rst_o |-> pc_q <= PC_LAST);
    assert_reload_after_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(wdt_rst_o) |-> (cnt_q[LOW_W-1:0] == '0));
endmodule

// File: tb/wdt_guard_tb_top.sv
module wdt_guard_tb_top;
    localparam int PER_FAST = 12 * 2 * 512;

    localparam logic [6:0] VEC [6] = '{
        7'b0110001,
        7'b1001000,
        7'b0111100,
        7'b0100101,
        7'b1000000,
        7'b0101101
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strap = 1'b0;
    logic bus_wr = 1'b0, wr_arm = 1'b0, wr_start = 1'b0;
    logic [6:0] reload = 7'h7F;
    logic presc_sel = 1'b0;
    logic flag_clr = 1'b0;
    logic wdt_rst, flag, running, pending;

    int cyc = 0;
    int errors = 0;
    int checks = 0;
    int t0;
    bit done = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdt_guard dut_i (
        .clk_i(clk), .rst_ni(rst_n), .strap_i(strap),
        .bus_wr_i(bus_wr), .wr_arm_i(wr_arm), .wr_start_i(wr_start),
        .reload_i(reload), .presc_sel_i(presc_sel), .flag_clr_i(flag_clr),
        .wdt_rst_o(wdt_rst), .flag_o(flag), .running_o(running),
        .arm_pending_o(pending)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic bus_write(input logic a, input logic s);
        @(negedge clk);
        bus_wr = 1'b1; wr_arm = a; wr_start = s;
        @(negedge clk);
        bus_wr = 1'b0; wr_arm = 1'b0; wr_start = 1'b0;
    endtask

    task automatic wait_until(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    task automatic do_reset(input logic s);
        @(negedge clk);
        rst_n = 1'b0; strap = s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t0 = cyc;
    endtask

    task automatic slot(input logic [1:0] code);
        case (code)
            2'd1: bus_write(1'b1, 1'b0);
            2'd2: bus_write(1'b0, 1'b1);
            2'd3: bus_write(1'b0, 1'b0);
            default: @(negedge clk);
        endcase
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        check("R1 reset running", running, 1'b0);
        check("R1 reset request", wdt_rst, 1'b0);
        check("R7 reset flag", flag, 1'b0);
        rst_n = 1'b1;
        t0 = cyc;
        repeat (3) @(negedge clk);
        strap = 1'b1;
        wait_until(t0 + 13000);
        check("R2 strap after reset", running, 1'b0);
        check("R1 idle no request", wdt_rst, 1'b0);
        strap = 1'b0;

        bus_write(1'b0, 1'b1);
        t0 = cyc;
        check("R3 start write", running, 1'b1);
        wait_until(t0 + PER_FAST - 1);
        check("R5 no early timeout", wdt_rst, 1'b0);
        wait_until(t0 + PER_FAST);
        check("R5 timeout on time", wdt_rst, 1'b1);
        check("R7 flag set", flag, 1'b1);
        wait_until(t0 + PER_FAST + 23);
        check("R6 pulse last cycle", wdt_rst, 1'b1);
        wait_until(t0 + PER_FAST + 24);
        check("R6 pulse ended", wdt_rst, 1'b0);
        check("R6 still running", running, 1'b1);
        check("R7 flag survives pulse", flag, 1'b1);
        t0 = t0 + PER_FAST + 24;
        wait_until(t0 + PER_FAST - 1);
        check("R6 reload no early", wdt_rst, 1'b0);
        wait_until(t0 + PER_FAST);
        check("R6 second timeout", wdt_rst, 1'b1);
        wait_until(t0 + PER_FAST + 30);
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
        check("R7 flag clear", flag, 1'b0);
        check("R8 still running", running, 1'b1);

        bus_write(1'b1, 1'b0);
        check("R4 pending after arm", pending, 1'b1);
        bus_write(1'b0, 1'b0);
        check("R4 other write cancels", pending, 1'b0);

        do_reset(1'b1);
        check("R1 strap high runs", running, 1'b1);
        strap = 1'b0;
        wait_until(t0 + PER_FAST - 1);
        check("R1 strap start not early", wdt_rst, 1'b0);
        wait_until(t0 + PER_FAST);
        check("R1 strap start timeout", wdt_rst, 1'b1);

        do_reset(1'b0);
        check("R8 reset strap low idles", running, 1'b0);
        bus_write(1'b0, 1'b1);

        foreach (VEC[i]) begin
            while (wdt_rst) @(negedge clk);
            bus_write(1'b1, 1'b0);
            bus_write(1'b0, 1'b1);
            t0 = cyc;
            wait_until(t0 + 6000);
            slot(VEC[i][6:5]);
            slot(VEC[i][4:3]);
            slot(VEC[i][2:1]);
            wait_until(t0 + PER_FAST);
            check($sformatf("R4 vector %0d", i), wdt_rst, ~VEC[i][0]);
            repeat (30) @(negedge clk);
        end

        while (wdt_rst) @(negedge clk);
        reload = 7'h7E;
        bus_write(1'b1, 1'b0);
        bus_write(1'b0, 1'b1);
        t0 = cyc;
        wait_until(t0 + 2 * PER_FAST - 1);
        check("R5 reload 7E not early", wdt_rst, 1'b0);
        wait_until(t0 + 2 * PER_FAST);
        check("R5 reload 7E timeout", wdt_rst, 1'b1);
        repeat (30) @(negedge clk);

        reload = 7'h7F;
        presc_sel = 1'b1;
        bus_write(1'b1, 1'b0);
        bus_write(1'b0, 1'b1);
        t0 = cyc;
        wait_until(t0 + PER_FAST);
        check("R5 slow prescale no fast timeout", wdt_rst, 1'b0);
        wait_until(t0 + 15000);
        check("R5 slow prescale still counting", wdt_rst, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule